// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire (I2C-style) serial bus placed in front of a byte-wide register-file array. A system clock samples SCL and SDA through two-flop synchronizers. Start and stop conditions are found by watching SDA move while SCL is high. The slave pulls SDA low through an open-drain enable and changes that enable only while SCL is low.

A transfer begins with a selection byte. Its top nibble is the type code 1010, then comes a mandatory 0, then two bits that must match the `dev_sel_i` straps, and last the direction bit (1 = read). A write-mode transfer carries a two-byte word address, high byte first, of which only the low `ADDR_W` bits are kept. It may then carry one data byte, which is stored. A read-mode transfer starts at the internal address counter. Reads go on in ascending order for as long as the master acknowledges each byte, and the counter wraps from the top of the array to zero. A random read is a write-mode selection byte plus the word address, then a repeated start and a read-mode selection byte.

States: `ST_IDLE` (bus free), `ST_DEVADDR` (shift selection byte), `ST_DEVACK` (acknowledge selection), `ST_ADDRHI`/`ST_ACKHI` (high address byte and its acknowledge), `ST_ADDRLO`/`ST_ACKLO` (low address byte and its acknowledge, counter loaded), `ST_WDATA`/`ST_WACK` (data byte, stored and acknowledged), `ST_RDATA` (drive eight bits), `ST_RACK` (sample master acknowledge), `ST_IGNORE` (bus released until the next start or stop). Transitions: any start goes to `ST_DEVADDR`, and any stop goes to `ST_IDLE`. `ST_DEVADDR` goes to `ST_DEVACK` on a match and to `ST_IGNORE` otherwise. `ST_DEVACK` goes to `ST_RDATA` when reading and to `ST_ADDRHI` when writing. The address and write states chain in order. `ST_WACK` goes to `ST_IGNORE`. `ST_RDATA` goes to `ST_RACK`. `ST_RACK` goes back to `ST_RDATA` on ACK and to `ST_IGNORE` on NACK. Apart from start and stop, state moves only on synchronized SCL falling edges.

Top module: `i2cmem_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_oe_o` = 0) and stays released while the bus is idle.
- R2: A selection byte whose bits 7..4 are 1010, whose bit 3 is 0 and whose bits 2..1 equal `dev_sel_i` is acknowledged by holding SDA low through the ninth SCL pulse.
- R3: Any other selection byte gets no acknowledge, and every later byte of that transfer is neither acknowledged nor acted on (no array write) until the next start.
- R4: In write mode the two following bytes form the word address, high byte first. Only the low `ADDR_W` bits are used, upper bits of the high byte are ignored, and both bytes are acknowledged.
- R5: A data byte after the word address is written to the array at the counter, is acknowledged, and advances the counter by one.
- R6: A second data byte in the same write transfer is not acknowledged and not stored.
- R7: A random read (write-mode selection, word address, repeated start, read-mode selection) returns the byte at the supplied address, MSB first.
- R8: During a read, a master ACK (SDA low on the ninth pulse) makes the slave send the byte at the next address. A NACK ends output, and SDA stays released until a stop or start.
- R9: The counter steps by one per byte read and wraps from 2^`ADDR_W`-1 to 0 with no break in the data stream.
- R10: A current-address read starts at the counter as left by the previous read or write, i.e. one past the last byte accessed.
- R11: The slave changes SDA only while synchronized SCL is low, and a start condition in any state releases SDA and restarts selection-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| dev_sel_i | input | 2 | Strap value the selection byte bits 2..1 must match |
| sda_oe_o | output | 1 | Pull SDA low when 1 (open-drain enable) |

## Verification
The two functions that meet in one step are the counter wrap and the continuation of a sequential read. The master's ACK for the byte at the top address and the fetch of the next byte happen around the same SCL falling edge, right after the counter has rolled to zero. The bench provokes this with a random read starting twelve locations below the top and a 29-byte acknowledged run across the boundary. Every byte is compared against the arithmetic pattern the bench wrote, and a current-address read afterwards confirms where the counter came to rest. A second overlap, a repeated start landing right after the low-address acknowledge, is exercised by every random read and judged by the returned byte.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_ADDRHI,
        ST_ACKHI,
        ST_ADDRLO,
        ST_ACKLO,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } i2c_state_e;

endpackage

// File: rtl/i2cmem_busmon.sv
module i2cmem_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_p;
    logic                   sda_p;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[0] <= 1'b1;
                    sda_pipe[0] <= 1'b1;
                end else begin
                    scl_pipe[0] <= scl_i;
                    sda_pipe[0] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe[i] <= 1'b1;
                    sda_pipe[i] <= 1'b1;
                end else begin
                    scl_pipe[i] <= scl_pipe[i-1];
                    sda_pipe[i] <= sda_pipe[i-1];
                end
            end
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edges and bus conditions, all in the synchronized domain
    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/i2cmem_addr_ctr.sv
module i2cmem_addr_ctr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // Load wins over increment; the natural AW-bit overflow is the wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + ONE;
        end
    end

endmodule

// File: rtl/i2cmem_regfile.sv
module i2cmem_regfile #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/i2cmem_slave.sv
module i2cmem_slave #(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] dev_sel_i,
    output logic       sda_oe_o
);

    import i2cmem_pkg::*;

    localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

    i2c_state_e state_q, state_d;

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]        bit_cnt_q;
    logic [7:0]        shreg_q;
    logic [HI_W-1:0]   hi_q;
    logic              mack_q;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] ld_val;
    logic [7:0]        mem_rdata;
    logic              rx_state, byte_in, sel_ok;
    logic              ptr_load, ptr_inc, mem_we, rd_done;

    i2cmem_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cmem_addr_ctr #(.AW(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ld_val),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    i2cmem_regfile #(.AW(ADDR_W), .DW(8)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (shreg_q),
        .rdata (mem_rdata)
    );

    // Word address assembly: only the low ADDR_W bits survive
    if (ADDR_W > 8) begin : g_wide
        assign ld_val = {hi_q, shreg_q};
    end else begin : g_narrow
        assign ld_val = shreg_q[ADDR_W-1:0];
    end

    assign rx_state = (state_q == ST_DEVADDR) || (state_q == ST_ADDRHI) ||
                      (state_q == ST_ADDRLO)  || (state_q == ST_WDATA);
    assign byte_in  = scl_fall && (bit_cnt_q == 4'd8);
    assign sel_ok   = (shreg_q[7:4] == DEV_TYPE) && !shreg_q[3] &&
                      (shreg_q[2:1] == dev_sel_i);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEVADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_IGNORE:  state_d = ST_IGNORE;
                ST_DEVADDR: if (byte_in)  state_d = sel_ok ? ST_DEVACK : ST_IGNORE;
                ST_DEVACK:  if (scl_fall) state_d = shreg_q[0] ? ST_RDATA : ST_ADDRHI;
                ST_ADDRHI:  if (byte_in)  state_d = ST_ACKHI;
                ST_ACKHI:   if (scl_fall) state_d = ST_ADDRLO;
                ST_ADDRLO:  if (byte_in)  state_d = ST_ACKLO;
                ST_ACKLO:   if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:   if (byte_in)  state_d = ST_WACK;
                ST_WACK:    if (scl_fall) state_d = ST_IGNORE;
                ST_RDATA:   if (scl_fall && bit_cnt_q == 4'd7) state_d = ST_RACK;
                ST_RACK:    if (scl_fall) state_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transition strobes toward the counter and array
    assign ptr_load = (state_q == ST_ADDRLO) && (state_d == ST_ACKLO);
    assign mem_we   = (state_q == ST_WDATA)  && (state_d == ST_WACK);
    assign rd_done  = (state_q == ST_RDATA)  && (state_d == ST_RACK);
    assign ptr_inc  = mem_we || rd_done;

    // Shift register, bit counter and captured bus bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            hi_q      <= '0;
            mack_q    <= 1'b0;
        end else begin
            if (start_det || stop_det) begin
                bit_cnt_q <= '0;
            end else if (state_d != state_q) begin
                bit_cnt_q <= '0;
                if (state_d == ST_RDATA) begin
                    shreg_q <= mem_rdata;
                end
            end else if (rx_state && scl_rise && bit_cnt_q != 4'd8) begin
                shreg_q   <= {shreg_q[6:0], sda_s};
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (state_q == ST_RDATA && scl_fall) begin
                shreg_q   <= {shreg_q[6:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end
            if ((state_q == ST_ADDRHI) && (state_d == ST_ACKHI)) begin
                hi_q <= shreg_q[HI_W-1:0];
            end
            if ((state_q == ST_RACK) && scl_rise) begin
                mack_q <= ~sda_s;
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_DEVACK, ST_ACKHI, ST_ACKLO, ST_WACK: sda_oe_o = 1'b1;
            ST_RDATA:                               sda_oe_o = ~shreg_q[7];
            default:                                sda_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2cmem_slave_chk.sv
module i2cmem_slave_chk #(
    parameter int AW = 11
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_s,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   sda_oe,
    input i2cmem_pkg::i2c_state_e state,
    input logic [7:0]             shreg,
    input logic [3:0]             bit_cnt,
    input logic [1:0]             dev_sel,
    input logic [AW-1:0]          ptr
);

    import i2cmem_pkg::*;

    assert_ack_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEVACK) |-> (shreg[7:4] == 4'b1010 && !shreg[3] && shreg[2:1] == dev_sel));

    assert_ignore_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IGNORE && !$past(start_det) && !$past(stop_det)) |-> (state == ST_IGNORE));

    assert_bitcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ptr) && $past(state) == ST_RDATA) |-> (ptr == $past(ptr) + AW'(1)));

    assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    assert_start_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

endmodule

bind i2cmem_slave i2cmem_slave_chk #(.AW(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe_o),
    .state     (state_q),
    .shreg     (shreg_q),
    .bit_cnt   (bit_cnt_q),
    .dev_sel   (dev_sel_i),
    .ptr       (ptr)
);

// File: tb/i2cmem_slave_bench.sv
module i2cmem_slave_bench;

    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam int H     = 6;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] dev_sel = 2'b10;
    logic       sda_oe;
    wire        sda_line = m_sda & ~sda_oe;

    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 1'b0;
    logic [7:0] exp_mem [DEPTH];
    bit         known   [DEPTH];

    always #4 clk = ~clk;

    i2cmem_slave #(.ADDR_W(AW)) u_i2cmem_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .dev_sel_i (dev_sel),
        .sda_oe_o  (sda_oe)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 91 + (a >> 8) * 13) & 255);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hw(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hw(H);
        m_scl = 1'b1; hw(H);
        m_sda = 1'b0; hw(H);
        m_scl = 1'b0; hw(1);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw(H);
        m_scl = 1'b1; hw(H);
        m_sda = 1'b1; hw(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; hw(H);
            m_scl = 1'b1; hw(H);
            m_scl = 1'b0; hw(1);
        end
        m_sda = 1'b1; hw(H);
        m_scl = 1'b1; hw(H / 2);
        ack = ~sda_line;
        hw(H - H / 2);
        m_scl = 1'b0; hw(1);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hw(H);
            m_scl = 1'b1; hw(H / 2);
            b = {b[6:0], sda_line};
            hw(H - H / 2);
            m_scl = 1'b0; hw(1);
        end
        m_sda = ~give_ack; hw(H);
        m_scl = 1'b1; hw(H);
        m_scl = 1'b0; hw(1);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] sel_byte(bit rd);
        return {4'b1010, 1'b0, dev_sel, rd};
    endfunction

    function automatic logic [7:0] hi_byte(int a);
        return {7'b1011001, 1'(a >> 8)};
    endfunction

    task automatic set_addr(int a);
        bit k;
        bus_start();
        send_byte(sel_byte(1'b0), k); chk(k, "R2", k, 1);
        send_byte(hi_byte(a), k);     chk(k, "R4", k, 1);
        send_byte(8'(a), k);          chk(k, "R4", k, 1);
    endtask

    task automatic write_one(int a, logic [7:0] d);
        bit k;
        set_addr(a);
        send_byte(d, k); chk(k, "R5", k, 1);
        bus_stop();
        exp_mem[a] = d;
        known[a]   = 1'b1;
    endtask

    task automatic rand_read(int a, output logic [7:0] d);
        bit k;
        set_addr(a);
        bus_start();
        send_byte(sel_byte(1'b1), k); chk(k, "R2", k, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        bit k;
        bus_start();
        send_byte(sel_byte(1'b1), k); chk(k, "R2", k, 1);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit         k1, k2;
        logic [7:0] d;
        int         a;

        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;

        // R1: reset state
        hw(5);
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        rst_n = 1'b1;
        hw(5);
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);

        // R2 / R3: every 7-bit selection value in write mode
        for (int v = 0; v < 128; v++) begin
            bit match;
            match = (v == {4'b1010, 1'b0, dev_sel});
            bus_start();
            send_byte(8'(v << 1), k1);
            send_byte(8'h00, k2);
            bus_stop();
            if (match) begin
                chk(k1 == 1'b1, "R2", k1, 1);
                chk(k2 == 1'b1, "R4", k2, 1);
            end else begin
                chk(k1 == 1'b0, "R3", k1, 0);
                chk(k2 == 1'b0, "R3", k2, 0);
            end
        end

        // R2: strap inputs steer the match
        dev_sel = 2'b01;
        bus_start(); send_byte(8'hA2, k1); bus_stop();
        chk(k1 == 1'b1, "R2", k1, 1);
        bus_start(); send_byte(8'hA4, k1); bus_stop();
        chk(k1 == 1'b0, "R3", k1, 0);
        dev_sel = 2'b10;

        // R5 / R4: fill a sparse pattern including both ends of the array
        for (int i = 0; i < DEPTH; i++) begin
            if ((i % 16) == 0 || i < 18 || i >= DEPTH - 12) write_one(i, pat(i));
        end

        // R3: writes after a wrong selection byte are dropped
        bus_start();
        send_byte(8'hA6, k1); chk(k1 == 1'b0, "R3", k1, 0);
        send_byte(8'h00, k1); chk(k1 == 1'b0, "R3", k1, 0);
        send_byte(8'h10, k1); chk(k1 == 1'b0, "R3", k1, 0);
        send_byte(8'h5A, k1); chk(k1 == 1'b0, "R3", k1, 0);
        bus_stop();
        rand_read(16, d);
        chk(d == exp_mem[16], "R3", d, exp_mem[16]);

        // R6: second data byte of a write is refused
        set_addr(DEPTH - 13);
        send_byte(8'hC3, k1); chk(k1 == 1'b1, "R5", k1, 1);
        send_byte(8'h3C, k2); chk(k2 == 1'b0, "R6", k2, 0);
        bus_stop();
        exp_mem[DEPTH-13] = 8'hC3;
        known[DEPTH-13]   = 1'b1;
        rand_read(DEPTH - 12, d);
        chk(d == exp_mem[DEPTH-12], "R6", d, exp_mem[DEPTH-12]);
        rand_read(DEPTH - 13, d);
        chk(d == 8'hC3, "R5", d, 8'hC3);

        // R7: random reads across the array (high address bit exercised)
        for (int i = 0; i < DEPTH; i += 48) begin
            a = i - (i % 16);
            rand_read(a, d);
            chk(d == exp_mem[a], "R7", d, exp_mem[a]);
        end

        // R10: current-address reads follow a read and a write
        rand_read(0, d);
        chk(d == exp_mem[0], "R7", d, exp_mem[0]);
        cur_read(d); chk(d == exp_mem[1], "R10", d, exp_mem[1]);
        cur_read(d); chk(d == exp_mem[2], "R10", d, exp_mem[2]);
        write_one(3, 8'h77);
        cur_read(d); chk(d == exp_mem[4], "R10", d, exp_mem[4]);

        // R8 / R9: acknowledged run across the top of the array
        set_addr(DEPTH - 12);
        bus_start();
        send_byte(sel_byte(1'b1), k1); chk(k1 == 1'b1, "R2", k1, 1);
        for (int n = 0; n < 29; n++) begin
            a = (DEPTH - 12 + n) % DEPTH;
            recv_byte(n != 28, d);
            if (a < DEPTH - 12) chk(d == exp_mem[a], "R9", d, exp_mem[a]);
            else                chk(d == exp_mem[a], "R8", d, exp_mem[a]);
        end
        hw(H);
        chk(sda_oe == 1'b0, "R8", sda_oe, 0);
        bus_stop();
        cur_read(d);
        chk(d == exp_mem[17], "R10", d, exp_mem[17]);

        // R11: start in the middle of a read restarts selection
        set_addr(5);
        bus_start();
        send_byte(sel_byte(1'b1), k1);
        recv_byte(1'b1, d);
        chk(d == exp_mem[5], "R8", d, exp_mem[5]);
        hw(H);
        if (sda_oe) begin
            // wait while the slave drives a zero bit, then restart after a released bit
            for (int i = 0; i < 8 && sda_oe; i++) begin
                m_scl = 1'b1; hw(H); m_scl = 1'b0; hw(H);
            end
        end
        bus_start();
        chk(sda_oe == 1'b0, "R11", sda_oe, 0);
        send_byte(sel_byte(1'b1), k1);
        chk(k1 == 1'b1, "R11", k1, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule